// File: doc/BRIEF.md
# Key-Indexed Match-Vector Lookup Table

This block is an associative lookup table with a fixed number of entries, each holding a small key. Instead of comparing the search key against every stored key, it keeps the match lines already decoded. A memory has one word per possible key value, and each word has one bit per entry. The bit for entry i is set in word k exactly when entry i holds key k. A lookup is therefore one memory read addressed by the search key. The word that comes out is the set of matching entries. It is reduced to a hit flag and the binary index of the lowest matching entry, ready to address a neighbouring data memory.

Updating an entry takes two steps. First the entry's bit is cleared in the word of the key it held before. Then the bit is set in the word of its new key. A small register file keeps each entry's current key and a valid flag, so the first step knows which word to clear. After reset, the block sweeps the memory to zero, one word per cycle, before it accepts any work. The `busy` output is high during both the sweep and every update.

Top module: `xcam`

## Requirements
- R1: After reset is released, `busy` stays high until the 2^KEY_W-th rising edge and then falls. Every search made after that misses until an entry is written.
- R2: The key on `srch_key` is sampled at a rising edge. The result for that key appears on `srch_hit`/`srch_idx` right after that same edge and holds until the next edge.
- R3: `srch_hit` is 1 when some written entry holds the searched key. `srch_idx` is then the binary number of that entry.
- R4: When several entries hold the searched key, `srch_idx` reports the lowest-numbered one.
- R5: An update is accepted at an edge where `wr_en` is 1 and `busy` is 0. `busy` is then high after that edge and after the next one, and low after the third. A search sampled at the edge where `busy` is first seen low already sees the new key.
- R6: After entry i is rewritten, its previous key no longer reports entry i. That key misses unless another entry holds it.
- R7: `wr_en` is ignored at any edge where `busy` is 1. Such a request neither starts a later update nor changes any entry.
- R8: A search sampled while `busy` is 1 returns `srch_hit` = 0.
- R9: Rewriting an entry with the key it already holds leaves that key reporting that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| srch_key | input | KEY_W | Key to look up, sampled every cycle |
| srch_hit | output | 1 | Some entry matched the key sampled at the last edge |
| srch_idx | output | IDX_W | Lowest matching entry number; 0 on a miss |
| wr_en | input | 1 | Request to load `wr_key` into entry `wr_idx` |
| wr_idx | input | IDX_W | Entry to update |
| wr_key | input | KEY_W | New key for the entry |
| busy | output | 1 | Reset sweep or update in progress; requests and searches are refused |

## Verification
The directed tests target the cases that a transposed table gets wrong most easily. The first is a stale bit when an entry moves to another key: the old key would still hit. The second is a rewrite to the same key: if the clear and the set were ordered the wrong way, the entry would vanish. The third is several entries sharing one key, which a wrong priority order would resolve to the highest index. The tests also probe the reset sweep length and the two-cycle busy window. They issue searches and a second update inside that window: a design that did not gate them would report hits on half-updated words or queue the refused request.

// File: rtl/xcam_pkg.sv
package xcam_pkg;

    typedef enum logic [1:0] {
        XS_INIT = 2'd0,
        XS_IDLE = 2'd1,
        XS_CLR  = 2'd2,
        XS_SET  = 2'd3
    } xcam_state_e;

endpackage

// File: rtl/xcam_match_ram.sv
module xcam_match_ram #(
    parameter int ADDR_W = 4,
    parameter int WIDTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WIDTH-1:0]  wmask,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WIDTH-1:0]  rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WIDTH-1:0] mem [DEPTH];

    // bit-masked write: only the masked bits of the word change
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= (mem[waddr] & ~wmask) | (wdata & wmask);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/xcam_entry_table.sv
module xcam_entry_table #(
    parameter int ENTRIES = 8,
    parameter int KEY_W   = 4,
    parameter int IDX_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [KEY_W-1:0] wkey,
    output logic [KEY_W-1:0] old_key,
    output logic             old_valid
);
    logic [KEY_W-1:0]   key_q [ENTRIES];
    logic [ENTRIES-1:0] valid_q;

    always_ff @(posedge clk) begin
        if (we) begin
            key_q[idx] <= wkey;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (we) begin
            valid_q[idx] <= 1'b1;
        end
    end

    assign old_key   = key_q[idx];
    assign old_valid = valid_q[idx];

endmodule

// File: rtl/xcam_prio_enc.sv
module xcam_prio_enc #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     match,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        hit = |match;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/xcam.sv
module xcam
    import xcam_pkg::*;
#(
    parameter  int ENTRIES = 8,
    parameter  int KEY_W   = 4,
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [KEY_W-1:0] srch_key,
    output logic             srch_hit,
    output logic [IDX_W-1:0] srch_idx,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [KEY_W-1:0] wr_key,
    output logic             busy
);
    localparam logic [KEY_W-1:0] LAST_WORD = {KEY_W{1'b1}};

    typedef struct packed {
        xcam_state_e      state;
        logic [KEY_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
        logic [KEY_W-1:0] key;
        logic             srch_ok;
    } ctrl_t;

    ctrl_t c_d, c_q;

    logic               ram_we;
    logic [KEY_W-1:0]   ram_waddr;
    logic [ENTRIES-1:0] ram_wmask;
    logic [ENTRIES-1:0] ram_wdata;
    logic [ENTRIES-1:0] ram_rdata;
    logic [ENTRIES-1:0] sel_bit;
    logic [ENTRIES-1:0] match;
    logic               tbl_we;
    logic [KEY_W-1:0]   old_key;
    logic               old_valid;

    always_comb begin
        c_d        = c_q;
        ram_we     = 1'b0;
        ram_waddr  = '0;
        ram_wmask  = '0;
        ram_wdata  = '0;
        tbl_we     = 1'b0;
        sel_bit    = '0;
        sel_bit[c_q.idx] = 1'b1;
        c_d.srch_ok = (c_q.state == XS_IDLE);
        case (c_q.state)
            XS_INIT: begin
                ram_we    = 1'b1;
                ram_waddr = c_q.cnt;
                ram_wmask = '1;
                c_d.cnt   = c_q.cnt + 1'b1;
                if (c_q.cnt == LAST_WORD) begin
                    c_d.state = XS_IDLE;
                end
            end
            XS_IDLE: begin
                if (wr_en) begin
                    c_d.idx   = wr_idx;
                    c_d.key   = wr_key;
                    c_d.state = XS_CLR;
                end
            end
            XS_CLR: begin
                ram_we    = old_valid;
                ram_waddr = old_key;
                ram_wmask = sel_bit;
                c_d.state = XS_SET;
            end
            XS_SET: begin
                ram_we    = 1'b1;
                ram_waddr = c_q.key;
                ram_wmask = sel_bit;
                ram_wdata = sel_bit;
                tbl_we    = 1'b1;
                c_d.state = XS_IDLE;
            end
            default: c_d.state = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{state: XS_INIT, cnt: '0, idx: '0, key: '0, srch_ok: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    xcam_match_ram #(.ADDR_W(KEY_W), .WIDTH(ENTRIES)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wmask (ram_wmask),
        .wdata (ram_wdata),
        .raddr (srch_key),
        .rdata (ram_rdata)
    );

    xcam_entry_table #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .IDX_W(IDX_W)) u_tbl (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (tbl_we),
        .idx       (c_q.idx),
        .wkey      (c_q.key),
        .old_key   (old_key),
        .old_valid (old_valid)
    );

    assign match = c_q.srch_ok ? ram_rdata : '0;

    xcam_prio_enc #(.N(ENTRIES), .IDX_W(IDX_W)) u_enc (
        .match (match),
        .hit   (srch_hit),
        .idx   (srch_idx)
    );

    assign busy = (c_q.state != XS_IDLE);

    // R1: the sweep visits consecutive words until it leaves
    a_r1_sweep_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == XS_INIT) |=>
            ((c_q.state == XS_IDLE) || (c_q.cnt == $past(c_q.cnt) + 1'b1)));

    // R4: no lower-numbered entry matched when a hit is reported
    a_r4_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
        srch_hit |-> ((match & ((ENTRIES'(1) << srch_idx) - 1'b1)) == '0));

    // R5: the clear step is always followed by the set step, then idle
    a_r5_clr_then_set: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == XS_CLR) |=> (c_q.state == XS_SET));
    a_r5_set_then_free: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == XS_SET) |=> !busy);

    // R7: a request during busy leaves the captured entry alone
    a_r7_req_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en) |=> $stable(c_q.idx));

    // R8: searches sampled while busy cannot hit
    a_r8_busy_miss: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !srch_hit);

endmodule

// File: tb/xcam_test.sv
module xcam_test;
    localparam int ENTRIES = 8;
    localparam int KEY_W   = 4;
    localparam int IDX_W   = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [KEY_W-1:0] srch_key = '0;
    logic             srch_hit;
    logic [IDX_W-1:0] srch_idx;
    logic             wr_en = 1'b0;
    logic [IDX_W-1:0] wr_idx = '0;
    logic [KEY_W-1:0] wr_key = '0;
    logic             busy;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    xcam #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) uut (
        .clk(clk), .rst_n(rst_n), .srch_key(srch_key), .srch_hit(srch_hit),
        .srch_idx(srch_idx), .wr_en(wr_en), .wr_idx(wr_idx), .wr_key(wr_key),
        .busy(busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // search sampled at the next edge; result checked just after it (R2)
    task automatic search(input int key, input bit exp_hit, input int exp_idx, input string req);
        @(negedge clk);
        srch_key = KEY_W'(key);
        @(posedge clk);
        #1;
        check(srch_hit == exp_hit, {req, " hit"}, int'(srch_hit), int'(exp_hit));
        if (exp_hit) check(int'(srch_idx) == exp_idx, {req, " idx"}, int'(srch_idx), exp_idx);
    endtask

    // update with its busy window checked (R5)
    task automatic write(input int idx, input int key);
        @(negedge clk);
        while (busy) @(negedge clk);
        wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_key = KEY_W'(key);
        @(posedge clk); #1;
        check(busy == 1'b1, "R5 busy after accept", int'(busy), 1);
        @(negedge clk); wr_en = 1'b0;
        @(posedge clk); #1;
        check(busy == 1'b1, "R5 busy second cycle", int'(busy), 1);
        @(posedge clk); #1;
        check(busy == 1'b0, "R5 busy released", int'(busy), 0);
    endtask

    task automatic t_reset();
        int n = 0;
        @(negedge clk); rst_n = 1'b1;
        check(busy == 1'b1, "R1 busy at release", int'(busy), 1);
        @(posedge clk); #1;
        while (busy && n < 100) begin n++; @(posedge clk); #1; end
        check(n == (1 << KEY_W) - 1, "R1 sweep length", n, (1 << KEY_W) - 1);
        for (int k = 0; k < (1 << KEY_W); k++) search(k, 1'b0, 0, "R1 empty miss");
    endtask

    task automatic t_basic();
        write(0, 5);
        search(5, 1'b1, 0, "R3 single hit");
        search(6, 1'b0, 0, "R2 next key result");
        search(5, 1'b1, 0, "R2 back to stored key");
    endtask

    task automatic t_multi();
        write(3, 9);
        write(1, 9);
        search(9, 1'b1, 1, "R4 lowest of two");
        write(1, 2);
        search(9, 1'b1, 3, "R6 moved entry leaves");
        search(2, 1'b1, 1, "R3 moved entry found");
    endtask

    task automatic t_move();
        write(0, 7);
        search(5, 1'b0, 0, "R6 old key gone");
        search(7, 1'b1, 0, "R3 new key");
    endtask

    task automatic t_same();
        write(3, 9);
        search(9, 1'b1, 3, "R9 same key kept");
    endtask

    task automatic t_busy();
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd4; wr_key = 4'd11; srch_key = 4'd0;
        @(posedge clk); #1;
        check(busy == 1'b1, "R5 accepted", int'(busy), 1);
        @(negedge clk);
        wr_idx = 3'd5; wr_key = 4'd12; srch_key = 4'd7;
        @(posedge clk); #1;
        check(srch_hit == 1'b0, "R8 search during busy", int'(srch_hit), 0);
        @(negedge clk); wr_en = 1'b0;
        @(posedge clk); #1;
        check(busy == 1'b0, "R7 no queued update", int'(busy), 0);
        @(posedge clk); #1;
        check(busy == 1'b0, "R7 still idle", int'(busy), 0);
        search(12, 1'b0, 0, "R7 refused key absent");
        search(11, 1'b1, 4, "R7 accepted update kept");
        search(7, 1'b1, 0, "R8 key back after busy");
    endtask

    task automatic t_fill();
        for (int i = 0; i < ENTRIES; i++) write(i, 15 - i);
        for (int i = 0; i < ENTRIES; i++) search(15 - i, 1'b1, i, "R3 full table");
        search(2, 1'b0, 0, "R6 overwritten key");
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_basic();
        t_multi();
        t_move();
        t_same();
        t_busy();
        t_fill();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule